// File: doc/BRIEF.md
# Nested Exception Fault Escalator

This block sits between the fault sources of a processor core and its exception delivery logic. Every time the core raises an exception it presents a vector, an error code and a flag telling whether the event came from a software interrupt instruction. The block remembers the vector of the exception whose delivery is still in progress. It decides whether the new event is delivered as raised, promoted to a double fault (vector 8, error code zero), or turned into a shutdown request because a double fault was already being delivered.

Faults fall into classes. Vector 0 and vectors 10, 11, 12 and 13 form the contributory class. The page fault is vector 14 and the double fault is vector 8. Every other vector is benign. The delivery logic pulses a completion input once the handler has been entered. That pulse empties the record, so the next fault is judged on its own. An empty record has its own encoding and is never confused with vector 0. Results are registered and qualified by a single-cycle valid pulse, or by a single-cycle shutdown pulse.

Top module: `fault_escalator`

## Requirements
- R1: After reset, `out_valid_o` and `shutdown_o` are low, `out_vec_o` and `out_err_o` are zero, and no prior exception is recorded, so a first fault on vector 0 is delivered unchanged.
- R2: The contributory vectors are 0, 10, 11, 12 and 13. A contributory fault raised while a contributory fault is recorded is delivered as vector 8 with error code 0.
- R3: A contributory fault or a page fault (vector 14) raised while a page fault is recorded is delivered as vector 8 with error code 0.
- R4: Every other pairing is delivered with its own vector and error code. This covers a page fault raised during a contributory fault and any benign vector (not 0, 8, 10 to 14).
- R5: A non-software raise while a double fault (vector 8) is recorded produces a one-cycle `shutdown_o` pulse with no `out_valid_o`, and it empties the record.
- R6: A raise with `swint_i` high is delivered unchanged, never escalates or shuts down, and leaves the record as it was.
- R7: After a non-software raise, the record takes the delivered vector when that vector is contributory, 14 or 8. A benign vector leaves the record unchanged.
- R8: A `done_i` pulse empties the record. When `done_i` and `raise_i` arrive in the same cycle, the raise is judged against an empty record.
- R9: For each raise, exactly one of `out_valid_o` or `shutdown_o` pulses for one cycle, one clock after the raise. Neither pulses otherwise, and `out_vec_o` and `out_err_o` hold their values between deliveries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| raise_i | input | 1 | Single-cycle strobe: an exception is raised |
| vec_i | input | VEC_W (8) | Vector of the raised exception |
| err_i | input | ERR_W (32) | Error code of the raised exception |
| swint_i | input | 1 | Raise comes from a software interrupt instruction |
| done_i | input | 1 | Delivery of the recorded exception has completed |
| out_valid_o | output | 1 | Delivered vector and error code are valid this cycle |
| out_vec_o | output | VEC_W (8) | Vector to deliver |
| out_err_o | output | ERR_W (32) | Error code to deliver |
| shutdown_o | output | 1 | Single-cycle shutdown (triple fault) request |

## Verification
The properties assume that `raise_i` and `done_i` are clean single-cycle strobes, synchronous to `clk` and free of unknowns. They also assume that `swint_i`, `vec_i` and `err_i` matter only in a raise cycle. The stimulus changes inputs only on the falling edge and holds each strobe for exactly one cycle. Its random phase draws vectors from a set that has every class, including the double fault itself and benign vectors on both sides of the contributory range, so that every pairing of recorded and new class occurs. Same-cycle raise and completion is exercised both in directed cases and at random.

// File: rtl/fesc_pkg.sv
package fesc_pkg;

  // Vector numbers whose class drives escalation
  localparam int unsigned DIV_VEC        = 0;
  localparam int unsigned DF_VEC         = 8;
  localparam int unsigned CONTRIB_LO_VEC = 10;
  localparam int unsigned CONTRIB_HI_VEC = 13;
  localparam int unsigned PF_VEC         = 14;

  typedef struct packed {
    logic contrib;
    logic page;
    logic dbl;
  } fesc_cls_t;

  typedef enum logic [1:0] {
    ACT_PASS     = 2'd0,
    ACT_DOUBLE   = 2'd1,
    ACT_SHUTDOWN = 2'd2
  } fesc_act_e;

endpackage

// File: rtl/fesc_class.sv
module fesc_class
  import fesc_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             present_i,
  input  logic [VEC_W-1:0] vec_i,
  output fesc_cls_t        cls_o
);

  localparam logic [VEC_W-1:0] DIV_V  = VEC_W'(DIV_VEC);
  localparam logic [VEC_W-1:0] LO_V   = VEC_W'(CONTRIB_LO_VEC);
  localparam logic [VEC_W-1:0] HI_V   = VEC_W'(CONTRIB_HI_VEC);
  localparam logic [VEC_W-1:0] PF_V   = VEC_W'(PF_VEC);
  localparam logic [VEC_W-1:0] DF_V   = VEC_W'(DF_VEC);

  logic in_range;

  always_comb begin
    in_range      = (vec_i >= LO_V) && (vec_i <= HI_V);
    cls_o.contrib = present_i && ((vec_i == DIV_V) || in_range);
    cls_o.page    = present_i && (vec_i == PF_V);
    cls_o.dbl     = present_i && (vec_i == DF_V);
  end

endmodule

// File: rtl/fesc_decide.sv
module fesc_decide
  import fesc_pkg::*;
(
  input  logic      raise_i,
  input  logic      swint_i,
  input  fesc_cls_t prior_i,
  input  fesc_cls_t new_i,
  output fesc_act_e act_o,
  output logic      rec_load_o,
  output logic      rec_kill_o
);

  logic pair_contrib;
  logic pair_page;

  always_comb begin
    pair_contrib = prior_i.contrib && new_i.contrib;
    pair_page    = prior_i.page && (new_i.contrib || new_i.page);

    if (swint_i) begin
      act_o = ACT_PASS;
    end else if (prior_i.dbl) begin
      act_o = ACT_SHUTDOWN;
    end else if (pair_contrib || pair_page) begin
      act_o = ACT_DOUBLE;
    end else begin
      act_o = ACT_PASS;
    end

    rec_kill_o = raise_i && !swint_i && (act_o == ACT_SHUTDOWN);
    rec_load_o = raise_i && !swint_i && (act_o != ACT_SHUTDOWN) &&
                 ((act_o == ACT_DOUBLE) || new_i.contrib || new_i.page || new_i.dbl);
  end

endmodule

// File: rtl/fesc_prior_reg.sv
module fesc_prior_reg #(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clear_i,
  input  logic             load_i,
  input  logic [VEC_W-1:0] load_vec_i,
  output logic             vld_o,
  output logic [VEC_W-1:0] vec_o
);

  logic             vld_d;
  logic [VEC_W-1:0] vec_d;
  logic             vec_en;

  always_comb begin
    vec_en = load_i;
    vec_d  = load_vec_i;
    if (load_i) begin
      vld_d = 1'b1;
    end else if (clear_i) begin
      vld_d = 1'b0;
    end else begin
      vld_d = vld_o;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_o <= 1'b0;
    end else begin
      vld_o <= vld_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_o <= '0;
    end else if (vec_en) begin
      vec_o <= vec_d;
    end
  end

endmodule

// File: rtl/fault_escalator.sv
module fault_escalator
  import fesc_pkg::*;
#(
  parameter int VEC_W = 8,
  parameter int ERR_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             raise_i,
  input  logic [VEC_W-1:0] vec_i,
  input  logic [ERR_W-1:0] err_i,
  input  logic             swint_i,
  input  logic             done_i,
  output logic             out_valid_o,
  output logic [VEC_W-1:0] out_vec_o,
  output logic [ERR_W-1:0] out_err_o,
  output logic             shutdown_o
);

  localparam logic [VEC_W-1:0] DF_V = VEC_W'(DF_VEC);
  localparam int               N_CLS = 2;

  logic             prior_vld_q;
  logic [VEC_W-1:0] prior_vec_q;
  logic             prior_live;

  logic             cls_present [N_CLS];
  logic [VEC_W-1:0] cls_vec     [N_CLS];
  fesc_cls_t        cls_out     [N_CLS];

  fesc_act_e        act;
  logic             rec_load;
  logic             rec_kill;
  logic             rec_clear;
  logic [VEC_W-1:0] rec_vec;

  logic             valid_d;
  logic             shut_d;
  logic             data_en;
  logic [VEC_W-1:0] vec_d;
  logic [ERR_W-1:0] err_d;

  // A completion in the same cycle retires the recorded exception first
  always_comb begin
    prior_live     = prior_vld_q && !done_i;
    cls_present[0] = prior_live;
    cls_vec[0]     = prior_vec_q;
    cls_present[1] = 1'b1;
    cls_vec[1]     = vec_i;
  end

  for (genvar g = 0; g < N_CLS; g++) begin : g_cls
    fesc_class #(.VEC_W(VEC_W)) u_cls (
      .present_i (cls_present[g]),
      .vec_i     (cls_vec[g]),
      .cls_o     (cls_out[g])
    );
  end

  fesc_decide u_decide (
    .raise_i    (raise_i),
    .swint_i    (swint_i),
    .prior_i    (cls_out[0]),
    .new_i      (cls_out[1]),
    .act_o      (act),
    .rec_load_o (rec_load),
    .rec_kill_o (rec_kill)
  );

  always_comb begin
    rec_vec   = (act == ACT_DOUBLE) ? DF_V : vec_i;
    rec_clear = done_i || rec_kill;
  end

  fesc_prior_reg #(.VEC_W(VEC_W)) u_prior (
    .clk        (clk),
    .rst_n      (rst_n),
    .clear_i    (rec_clear),
    .load_i     (rec_load),
    .load_vec_i (rec_vec),
    .vld_o      (prior_vld_q),
    .vec_o      (prior_vec_q)
  );

  // Output stage: next-state
  always_comb begin
    valid_d = raise_i && (act != ACT_SHUTDOWN);
    shut_d  = raise_i && (act == ACT_SHUTDOWN);
    data_en = valid_d;
    if (act == ACT_DOUBLE) begin
      vec_d = DF_V;
      err_d = '0;
    end else begin
      vec_d = vec_i;
      err_d = err_i;
    end
  end

  // Output stage: registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid_o <= 1'b0;
      shutdown_o  <= 1'b0;
    end else begin
      out_valid_o <= valid_d;
      shutdown_o  <= shut_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vec_o <= '0;
      out_err_o <= '0;
    end else if (data_en) begin
      out_vec_o <= vec_d;
      out_err_o <= err_d;
    end
  end

endmodule

// File: rtl/fesc_chk.sv
module fesc_chk #(
  parameter int VEC_W = 8,
  parameter int ERR_W = 32
) (
  input logic             clk,
  input logic             rst_n,
  input logic             raise_i,
  input logic [VEC_W-1:0] vec_i,
  input logic [ERR_W-1:0] err_i,
  input logic             swint_i,
  input logic             done_i,
  input logic             out_valid_o,
  input logic [VEC_W-1:0] out_vec_o,
  input logic [ERR_W-1:0] out_err_o,
  input logic             shutdown_o,
  input logic             prior_vld,
  input logic [VEC_W-1:0] prior_vec
);

  logic new_con, new_pf, new_df, old_con, old_pf, old_df, fault_vs_rec;

  always_comb begin
    new_con = (vec_i == 0) || ((vec_i >= 10) && (vec_i <= 13));
    new_pf  = (vec_i == 14);
    new_df  = (vec_i == 8);
    old_con = prior_vld && ((prior_vec == 0) || ((prior_vec >= 10) && (prior_vec <= 13)));
    old_pf  = prior_vld && (prior_vec == 14);
    old_df  = prior_vld && (prior_vec == 8);
    fault_vs_rec = raise_i && !swint_i && !done_i;
  end

  p_one_outcome_r9: assert property (@(posedge clk) disable iff (!rst_n)
    raise_i |=> (out_valid_o ^ shutdown_o));

  p_no_spurious_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !raise_i |=> (!out_valid_o && !shutdown_o && $stable(out_vec_o) && $stable(out_err_o)));

  p_swint_bypass_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && swint_i) |=>
      (out_valid_o && out_vec_o == $past(vec_i) && out_err_o == $past(err_i)));

  p_clean_after_done_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (raise_i && done_i && !swint_i) |=>
      (out_valid_o && out_vec_o == $past(vec_i) && out_err_o == $past(err_i)));

  p_triple_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vs_rec && old_df) |=> (shutdown_o && !out_valid_o && !prior_vld));

  p_contrib_pair_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vs_rec && old_con && new_con) |=>
      (out_valid_o && out_vec_o == 8 && out_err_o == 0));

  p_page_pair_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vs_rec && old_pf && (new_con || new_pf)) |=>
      (out_valid_o && out_vec_o == 8 && out_err_o == 0));

  p_benign_keeps_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_vs_rec && prior_vld && !old_df && !new_con && !new_pf && !new_df) |=>
      (prior_vld && prior_vec == $past(prior_vec)));

endmodule

bind fault_escalator fesc_chk #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .raise_i     (raise_i),
  .vec_i       (vec_i),
  .err_i       (err_i),
  .swint_i     (swint_i),
  .done_i      (done_i),
  .out_valid_o (out_valid_o),
  .out_vec_o   (out_vec_o),
  .out_err_o   (out_err_o),
  .shutdown_o  (shutdown_o),
  .prior_vld   (prior_vld_q),
  .prior_vec   (prior_vec_q)
);

// File: tb/sim_fault_escalator.sv
`timescale 1ns/1ps
module sim_fault_escalator;

  localparam int CLK_PERIOD = 10;
  localparam int VEC_W = 8;
  localparam int ERR_W = 32;

  logic             clk;
  logic             rst_n;
  logic             raise_i;
  logic [VEC_W-1:0] vec_i;
  logic [ERR_W-1:0] err_i;
  logic             swint_i;
  logic             done_i;
  logic             out_valid_o;
  logic [VEC_W-1:0] out_vec_o;
  logic [ERR_W-1:0] out_err_o;
  logic             shutdown_o;

  int    n_checks = 0;
  int    n_fail   = 0;
  int    cyc      = 0;
  bit    finished = 0;
  string cur_req  = "R1";

  fault_escalator #(.VEC_W(VEC_W), .ERR_W(ERR_W)) u0 (
    .clk(clk), .rst_n(rst_n), .raise_i(raise_i), .vec_i(vec_i), .err_i(err_i),
    .swint_i(swint_i), .done_i(done_i), .out_valid_o(out_valid_o),
    .out_vec_o(out_vec_o), .out_err_o(out_err_o), .shutdown_o(shutdown_o)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  bit          m_valid, m_shut;
  int          m_vec;
  logic [31:0] m_err;
  int          m_prior;   // -1 means nothing recorded

  function automatic bit is_con(int v);
    return (v == 0) || (v >= 10 && v <= 13);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_valid <= 0; m_shut <= 0; m_vec <= 0; m_err <= '0; m_prior <= -1;
    end else begin
      int p;
      int v;
      p = done_i ? -1 : m_prior;
      v = int'(vec_i);
      m_valid <= 0;
      m_shut  <= 0;
      if (raise_i) begin
        if (swint_i) begin
          m_valid <= 1; m_vec <= v; m_err <= err_i;
        end else if (p == 8) begin
          m_shut <= 1; p = -1;
        end else if ((is_con(p) && is_con(v)) || (p == 14 && (is_con(v) || v == 14))) begin
          m_valid <= 1; m_vec <= 8; m_err <= '0; p = 8;
        end else begin
          m_valid <= 1; m_vec <= v; m_err <= err_i;
          if (is_con(v) || v == 14 || v == 8) p = v;
        end
      end
      m_prior <= p;
    end
  end

  task automatic compare();
    n_checks++;
    if (out_valid_o !== m_valid || shutdown_o !== m_shut ||
        out_vec_o !== m_vec[VEC_W-1:0] || out_err_o !== m_err) begin
      n_fail++;
      $display("FAIL %s: got valid=%0b shut=%0b vec=%0d err=%h, expected valid=%0b shut=%0b vec=%0d err=%h",
               cur_req, out_valid_o, shutdown_o, out_vec_o, out_err_o,
               m_valid, m_shut, m_vec, m_err);
    end
  endtask

  // One cycle: check outputs on the falling edge, then apply the next inputs
  task automatic drive(bit r, int v, logic [31:0] e, bit s, bit d);
    @(negedge clk);
    compare();
    raise_i = r; vec_i = VEC_W'(v); err_i = e; swint_i = s; done_i = d;
  endtask

  task automatic fault(int v, logic [31:0] e);
    drive(1, v, e, 0, 0);
  endtask

  task automatic idle();
    drive(0, 0, '0, 0, 0);
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: got cycle=%0d, expected completion before 150000", cyc);
      finish_run();
    end
  end

  initial begin
    rst_n = 0; raise_i = 0; vec_i = '0; err_i = '0; swint_i = 0; done_i = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1: reset state, then vector 0 against an empty record
    cur_req = "R1";
    idle(); idle();
    fault(0, 32'h1111_0000); idle();
    drive(0, 0, '0, 0, 1); idle();

    // R2: contributory during contributory
    cur_req = "R2";
    fault(13, 32'hAAAA_0001); fault(0, 32'hBBBB_0002); idle();
    drive(0, 0, '0, 0, 1);
    fault(10, 32'h10); fault(12, 32'h12); idle();
    drive(0, 0, '0, 0, 1);

    // R3: page fault or contributory during page fault
    cur_req = "R3";
    fault(14, 32'h0000_0007); fault(14, 32'h0000_0005); idle();
    drive(0, 0, '0, 0, 1);
    fault(14, 32'h2); fault(11, 32'h3); idle();
    drive(0, 0, '0, 0, 1);

    // R4: page fault during contributory, and benign vectors, pass unchanged
    cur_req = "R4";
    fault(10, 32'h55); fault(14, 32'h66); idle();
    fault(1, 32'h77); fault(2, 32'h88); fault(255, 32'h99); idle();
    drive(0, 0, '0, 0, 1);

    // R5: any fault during a double fault requests shutdown and empties the record
    cur_req = "R5";
    fault(8, 32'h0); fault(3, 32'hC0); idle();
    fault(0, 32'hC1); idle();
    drive(0, 0, '0, 0, 1);
    fault(13, 32'h1); fault(13, 32'h2); fault(14, 32'h3); idle();
    drive(0, 0, '0, 0, 1);

    // R6: software interrupts bypass escalation and leave the record
    cur_req = "R6";
    fault(14, 32'hE); drive(1, 14, 32'hDEAD_BEEF, 1, 0); fault(14, 32'hF); idle();
    drive(1, 3, 32'h3, 1, 0); idle();
    drive(0, 0, '0, 0, 1);

    // R7: benign vector leaves the recorded fault in place
    cur_req = "R7";
    fault(13, 32'h13); fault(3, 32'h3); fault(12, 32'h12); idle();
    drive(0, 0, '0, 0, 1);

    // R8: completion empties the record, also in the same cycle as a raise
    cur_req = "R8";
    fault(12, 32'h12); drive(0, 0, '0, 0, 1); fault(11, 32'h11); idle();
    fault(12, 32'h12); drive(1, 11, 32'h11, 0, 1); idle();
    drive(0, 0, '0, 0, 1);

    // R9: back-to-back raises and long idle hold
    cur_req = "R9";
    fault(2, 32'hF00D); idle(); idle(); idle();
    drive(1, 4, 32'h4, 1, 0); fault(5, 32'h5); idle(); idle();

    // Random mix covering every class pairing
    cur_req = "R2/R3/R4/R5/R7";
    for (int i = 0; i < 3000; i++) begin
      int pick;
      int vset [10] = '{0, 1, 3, 8, 9, 10, 13, 14, 15, 200};
      bit r, s, d;
      pick = $urandom_range(0, 9);
      r = ($urandom_range(0, 9) < 6);
      s = ($urandom_range(0, 9) == 0);
      d = ($urandom_range(0, 9) < 2);
      drive(r, vset[pick], $urandom, s, d);
    end
    idle(); idle();

    finish_run();
  end

endmodule